// File: doc/BRIEF.md
# Timed PCM sample fetch engine

This block plays back a stretch of 8-bit samples held in memory. Software programs a start location and a length through four byte-wide registers on a CPU bus, then sets an enable bit. From then on, a cycle divider expires once every `PERIOD` clock cycles. On each expiry the block issues one memory read at the next sample location. One cycle later the returned byte, halved, is placed on a 7-bit DAC output together with a one-cycle strobe. Each clock cycle stands for one CPU cycle.

Once the programmed number of samples has been fetched, the next expiry stops playback and raises a level interrupt. The interrupt stays up until software writes the control register again. A separate mode register gates the whole feature. While its bit 4 is clear, the start, length and control registers take no writes. In that state the control offset also reads back the host status byte unchanged. While bit 4 is set, bit 7 of that readback is replaced by the end-of-sample flag.

Top module: `pcm_fetch_engine`

## Requirements
- R1: A synchronous reset clears the interrupt, the enable, the DAC output and its strobe, the memory request and the read data, and loads the divider period with 225 cycles.
- R2: Register offsets on `cpu_addr` are 0 = mode, 1 = start, 2 = length, 3 = control/status. Writes to offsets 1, 2 and 3 have no effect unless mode bit 4 is set.
- R3: A gated write of byte B to the start register sets the sample pointer to B·64. A gated write of B to the length register makes the next run fetch exactly B·16+1 samples.
- R4: A gated control write clears the interrupt and reloads the divider with the period. Bit 4 = 1 starts playback and bit 4 = 0 stops it, so no further fetches occur.
- R5: The first fetch request comes exactly `PERIOD` cycles after the control write takes effect. Later fetches follow every `PERIOD` cycles.
- R6: The fetch address is the 15-bit pointer ORed with (mode[1:0] XOR 3) shifted left by 14. The pointer then increments by one.
- R7: The expiry after the last sample sets the interrupt and clears the enable. No memory request is made for that expiry.
- R8: `mem_req` is a one-cycle pulse. The cycle after `mem_valid`, `dac_data` holds `mem_rdata` shifted right by one and `dac_wr` pulses for one cycle.
- R9: A read presents data on `cpu_rdata` one cycle later. Offset 0 returns the mode register. Offset 3 returns the host status, with bit 7 replaced by the interrupt flag when mode bit 4 is set. Offsets 1 and 2 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CPU cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 2 | Register offset |
| cpu_wdata | input | 8 | Write data |
| host_status | input | 8 | Status byte of the surrounding audio unit |
| cpu_rdata | output | 8 | Registered read data |
| mem_req | output | 1 | One-cycle sample read request |
| mem_addr | output | 16 | Sample read address |
| mem_valid | input | 1 | Read data valid, one cycle after the request |
| mem_rdata | input | 8 | Sample byte |
| dac_data | output | 7 | DAC sample value |
| dac_wr | output | 1 | DAC update strobe |
| irq | output | 1 | End-of-sample interrupt, level |

## Verification
The assertions assume three things about the environment. The memory answers every request with `mem_valid` exactly one cycle later and never raises it unprompted. `PERIOD` is at least 2, so expiries never fall on adjacent cycles. Start and length registers are not rewritten in the same cycle as an expiry. The stimulus models the memory as a fixed one-cycle responder returning a computed pattern. It writes start and length only while playback is idle, or far from an expiry edge. A behavioural model in the bench tracks the divider, the signed sample count and the data pipeline, and it is compared against the ports on every clock.

// File: rtl/pcm_fetch_pkg.sv
package pcm_fetch_pkg;
  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_START = 2'd1,
    REG_LEN   = 2'd2,
    REG_CTRL  = 2'd3
  } pcm_reg_e;

  localparam int unsigned DEF_PERIOD = 225;
endpackage

// File: rtl/pcm_regs.sv
module pcm_regs
  import pcm_fetch_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int GATE_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] host_status,
  input  logic              irq_flag,
  output logic [DATA_W-1:0] mode_q,
  output logic              start_wr,
  output logic              len_wr,
  output logic              ctrl_wr,
  output logic [DATA_W-1:0] rdata
);
  pcm_reg_e    sel;
  logic        gate;
  logic [DATA_W-1:0] rd_mux;

  assign sel  = pcm_reg_e'(addr);
  assign gate = mode_q[GATE_BIT];

  always_comb begin
    start_wr = wr_en && (sel == REG_START) && gate;
    len_wr   = wr_en && (sel == REG_LEN)   && gate;
    ctrl_wr  = wr_en && (sel == REG_CTRL)  && gate;
    case (sel)
      REG_MODE: rd_mux = mode_q;
      REG_CTRL: rd_mux = gate ? {irq_flag, host_status[DATA_W-2:0]} : host_status;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      rdata  <= '0;
    end else begin
      if (wr_en && sel == REG_MODE) mode_q <= wdata;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R9: ungated status read passes the host byte through untouched
  assert_status_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == REG_CTRL && !gate) |=> rdata == $past(host_status));
  // R2: gated strobes never appear while the gate bit is clear
  assert_gate_closed_R2: assert property (@(posedge clk) disable iff (rst)
    !gate |-> !(start_wr || len_wr || ctrl_wr));
endmodule

// File: rtl/pcm_pacer.sv
module pcm_pacer #(
  parameter int PERIOD = 225
) (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic ctrl_en,
  input  logic end_hit,
  output logic tick,
  output logic active
);
  localparam int CNT_W = $clog2(PERIOD + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD);

  logic [CNT_W-1:0] cnt_q;
  logic             en_q;

  assign tick   = en_q && (cnt_q <= CNT_W'(1)) && !ctrl_wr;
  assign active = en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      cnt_q <= RELOAD;
    end else if (ctrl_wr) begin
      en_q  <= ctrl_en;
      cnt_q <= RELOAD;
    end else if (tick) begin
      cnt_q <= RELOAD;
      if (end_hit) en_q <= 1'b0;
    end else if (en_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5: expiries are never on adjacent cycles
  assert_tick_gap_R5: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R5: the count stays inside 1..PERIOD while running
  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
    en_q |-> (cnt_q != '0 && cnt_q <= RELOAD));
  // R7: the final expiry stops playback
  assert_end_stops_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && end_hit) |=> !en_q);
endmodule

// File: rtl/pcm_sequencer.sv
module pcm_sequencer #(
  parameter int DATA_W     = 8,
  parameter int PTR_W      = 15,
  parameter int LEN_W      = 13,
  parameter int ADDR_SHIFT = 6,
  parameter int LEN_SHIFT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_wr,
  input  logic              len_wr,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        mode_lo,
  input  logic              tick,
  output logic              end_hit,
  output logic              mem_req,
  output logic [PTR_W:0]    mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-2:0] dac_data,
  output logic              dac_wr,
  output logic              irq
);
  localparam int MA_W = PTR_W + 1;

  logic [PTR_W-1:0] ptr_q;
  logic [LEN_W-1:0] len_q;
  logic [MA_W-1:0]  fetch_addr;

  assign end_hit    = tick && (len_q == '0);
  assign fetch_addr = {1'b0, ptr_q} | (MA_W'(mode_lo ^ 2'b11) << (PTR_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      len_q    <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      dac_data <= '0;
      dac_wr   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      dac_wr  <= 1'b0;
      if (tick) begin
        if (len_q == '0) begin
          irq <= 1'b1;
        end else begin
          len_q    <= len_q - 1'b1;
          ptr_q    <= ptr_q + 1'b1;
          mem_req  <= 1'b1;
          mem_addr <= fetch_addr;
        end
      end
      if (start_wr) ptr_q <= PTR_W'(wdata) << ADDR_SHIFT;
      if (len_wr)   len_q <= (LEN_W'(wdata) << LEN_SHIFT) + 1'b1;
      if (ctrl_wr)  irq   <= 1'b0;
      if (mem_valid) begin
        dac_data <= mem_rdata[DATA_W-1:1];
        dac_wr   <= 1'b1;
      end
    end
  end

  // R8: memory request is a single-cycle pulse
  assert_req_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  // R8: a DAC strobe always follows returned data
  assert_dac_follows_R8: assert property (@(posedge clk) disable iff (rst)
    dac_wr |-> $past(mem_valid));
  // R4: a control write drops the interrupt
  assert_irq_clear_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> !irq);
  // R6: pointer advances by one per fetch
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && len_q != '0 && !start_wr) |=> ptr_q == $past(ptr_q) + 1'b1);
  // R3: the remaining count moves only on a fetch or a length write
  assert_len_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(tick || len_wr) |=> $stable(len_q));
endmodule

// File: rtl/pcm_fetch_engine.sv
module pcm_fetch_engine
  import pcm_fetch_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PTR_W      = 15,
  parameter int LEN_W      = 13,
  parameter int ADDR_SHIFT = 6,
  parameter int LEN_SHIFT  = 4,
  parameter int GATE_BIT   = 4,
  parameter int PERIOD     = DEF_PERIOD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] host_status,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic [PTR_W:0]    mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-2:0] dac_data,
  output logic              dac_wr,
  output logic              irq
);
  logic [DATA_W-1:0] mode_q;
  logic start_wr, len_wr, ctrl_wr;
  logic tick, end_hit, active;

  pcm_regs #(.DATA_W(DATA_W), .GATE_BIT(GATE_BIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cpu_wr), .rd_en(cpu_rd), .addr(cpu_addr),
    .wdata(cpu_wdata), .host_status(host_status), .irq_flag(irq),
    .mode_q(mode_q), .start_wr(start_wr), .len_wr(len_wr), .ctrl_wr(ctrl_wr),
    .rdata(cpu_rdata)
  );

  pcm_pacer #(.PERIOD(PERIOD)) u_pacer (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_en(cpu_wdata[GATE_BIT]),
    .end_hit(end_hit), .tick(tick), .active(active)
  );

  pcm_sequencer #(
    .DATA_W(DATA_W), .PTR_W(PTR_W), .LEN_W(LEN_W),
    .ADDR_SHIFT(ADDR_SHIFT), .LEN_SHIFT(LEN_SHIFT)
  ) u_seq (
    .clk(clk), .rst(rst), .start_wr(start_wr), .len_wr(len_wr),
    .ctrl_wr(ctrl_wr), .wdata(cpu_wdata), .mode_lo(mode_q[1:0]),
    .tick(tick), .end_hit(end_hit), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .dac_data(dac_data),
    .dac_wr(dac_wr), .irq(irq)
  );

  // R7: the interrupt only rises as playback ends
  assert_irq_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !active);
  // R4: no fetch is issued once playback is off
  assert_no_fetch_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !active |=> !mem_req);
endmodule

// File: tb/pcm_fetch_engine_bench.sv
module pcm_fetch_engine_bench;
  localparam int P = 225;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [1:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  host_status = 8'h5A;
  logic [7:0]  cpu_rdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [6:0]  dac_data;
  logic        dac_wr;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pcm_fetch_engine u_pcm_fetch_engine (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .host_status(host_status), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .dac_data(dac_data), .dac_wr(dac_wr), .irq(irq)
  );

  function automatic logic [7:0] pat(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // one-cycle memory responder
  always @(posedge clk) begin
    mem_valid <= mem_req;
    mem_rdata <= pat(mem_addr);
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0]  m_mode, m_rdata, m_dac_data;
  int          m_ptr, m_size, m_latch;
  bit          m_en, m_irq, m_req, m_valid, m_dac_wr;
  logic [15:0] m_addr;
  logic [7:0]  m_vdata;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_rdata = 0; m_dac_data = 0; m_ptr = 0; m_size = 0;
      m_latch = P; m_en = 0; m_irq = 0; m_req = 0; m_valid = 0; m_dac_wr = 0;
      m_addr = 0; m_vdata = 0;
    end else begin
      bit gate, ctrlw;
      logic [7:0] nxt;
      m_dac_wr = m_valid;
      if (m_valid) m_dac_data = {1'b0, m_vdata[7:1]};
      m_valid = m_req;
      m_vdata = pat(m_addr);
      m_req = 0;
      gate  = m_mode[4];
      ctrlw = cpu_wr && cpu_addr == 2'd3 && gate;
      if (cpu_rd) begin
        case (cpu_addr)
          2'd0: nxt = m_mode;
          2'd3: nxt = gate ? {m_irq, host_status[6:0]} : host_status;
          default: nxt = 8'h00;
        endcase
        m_rdata = nxt;
      end
      if (!ctrlw && m_en) begin
        m_latch--;
        if (m_latch <= 0) begin
          m_latch += P;
          m_size--;
          if (m_size < 0) begin
            m_irq = 1; m_en = 0;
          end else begin
            m_req  = 1;
            m_addr = 16'(m_ptr | ((int'(m_mode[1:0]) ^ 3) << 14));
            m_ptr  = (m_ptr + 1) & 32'h7FFF;
          end
        end
      end
      if (cpu_wr) begin
        case (cpu_addr)
          2'd0: m_mode = cpu_wdata;
          2'd1: if (gate) m_ptr = (int'(cpu_wdata) << 6) & 32'h7FFF;
          2'd2: if (gate) m_size = (int'(cpu_wdata) << 4) + 1;
          default: if (gate) begin
            m_en = cpu_wdata[4]; m_irq = 0; m_latch = P;
          end
        endcase
      end
    end
  end

  // per-clock comparison and fetch monitor
  int fetch_cnt = 0;
  logic [15:0] last_addr = '0;
  logic [6:0]  last_dac = '0;
  always @(negedge clk) begin
    if (!rst) begin
      check("R7 irq", irq, m_irq);
      check("R5 mem_req", mem_req, m_req);
      if (m_req) check("R6 mem_addr", mem_addr, m_addr);
      check("R8 dac_wr", dac_wr, m_dac_wr);
      if (m_dac_wr) check("R8 dac_data", dac_data, m_dac_data[6:0]);
      check("R9 cpu_rdata", cpu_rdata, m_rdata);
      if (mem_req) begin fetch_cnt++; last_addr = mem_addr; end
      if (dac_wr) last_dac = dac_data;
    end
  end

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cpu_rd = 1; cpu_addr = a;
    @(negedge clk); cpu_rd = 0; d = cpu_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    int n;
    int base;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check("R1 irq", irq, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 dac_wr", dac_wr, 0);
    check("R1 dac_data", dac_data, 0);
    check("R1 cpu_rdata", cpu_rdata, 0);

    // R2: gate closed, writes ignored, status passes through
    host_status = 8'hC3;
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd1, 8'h05);
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd3, 8'h10);
    repeat (3 * P) @(negedge clk);
    check("R2 no fetch when gate off", fetch_cnt, 0);
    rd_reg(2'd3, rd);
    check("R9 ungated status", rd, 8'hC3);

    // R3/R5/R6/R7: single sample run, mode low bits 0
    host_status = 8'h5A;
    wr_reg(2'd0, 8'h10);
    rd_reg(2'd0, rd);
    check("R9 mode readback", rd, 8'h10);
    wr_reg(2'd1, 8'h02);
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd3, 8'h10);
    n = 0;
    while (!mem_req && n < 4 * P) begin @(negedge clk); n++; end
    check("R5 first fetch delay", n, P);
    check("R6 first address", mem_addr, 16'hC080);
    repeat (P + 10) @(negedge clk);
    check("R3 one sample fetched", fetch_cnt, 1);
    check("R8 dac value", last_dac, 7'(pat(16'hC080) >> 1));
    check("R7 irq set", irq, 1);
    rd_reg(2'd3, rd);
    check("R9 gated status", rd, 8'hDA);
    rd_reg(2'd1, rd);
    check("R9 start reads zero", rd, 8'h00);
    wr_reg(2'd3, 8'h00);
    check("R4 irq cleared", irq, 0);

    // R3/R6: 17 samples, mode low bits 2
    base = fetch_cnt;
    wr_reg(2'd0, 8'h12);
    wr_reg(2'd1, 8'h01);
    wr_reg(2'd2, 8'h01);
    wr_reg(2'd3, 8'h10);
    repeat (18 * P + 10) @(negedge clk);
    check("R3 seventeen samples", fetch_cnt - base, 17);
    check("R6 last address", last_addr, 16'h4050);
    check("R7 irq after run", irq, 1);

    // R4: stop mid-run
    base = fetch_cnt;
    wr_reg(2'd2, 8'h01);
    wr_reg(2'd3, 8'h10);
    check("R4 irq cleared by enable", irq, 0);
    repeat (3 * P + P / 2) @(negedge clk);
    check("R5 three fetches", fetch_cnt - base, 3);
    wr_reg(2'd3, 8'h00);
    repeat (3 * P) @(negedge clk);
    check("R4 no fetch after stop", fetch_cnt - base, 3);
    check("R4 no irq after stop", irq, 0);

    finish_run();
  end
endmodule